// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block sits on the master side of a bus. It moves one operand per request between the core and a slave port whose width it does not know in advance. The operand can be a byte, a word or a long word. The port can be 8, 16 or 32 bits wide, and the operand may start at any byte address. The slave reports its real width with the acknowledge of every bus cycle. The sequencer then works out how many bytes that cycle actually moved. It advances the address and repeats cycles until no operand bytes remain.

Each bus cycle drives four things: the address of the most significant byte still outstanding, a two-bit code for the number of bytes still outstanding, a direction flag and a strobe. On writes, the outstanding bytes are copied onto every data lane that a narrow or wide port could sample. On reads, the bytes from the lanes that the acknowledged port used are merged into a holding register. That register is presented with a one-clock done pulse after the final cycle.

Top module: `dbs_seq`

## Requirements
- R1: `req_ready` is high whenever no sequence is in progress and low while one is. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the first bus cycle starts on the next cycle.
- R2: During every bus cycle, `bus_siz` gives the number of operand bytes not yet moved: 01 = one, 10 = two, 11 = three, 00 = four. A request's `req_size` uses 01 for byte, 10 for word and 00 for long word.
- R3: The first cycle's `bus_addr` equals `req_addr`. After each acknowledged cycle, the address advances by the number of bytes that cycle moved, so its low bits always point at the most significant outstanding byte.
- R4: `bus_ack` encodes 01 = 8-bit port, 10 = 16-bit port, 11 = 32-bit port and 00 = wait. While 00 is sampled, the cycle stays open with address, size code and strobe unchanged.
- R5: A cycle moves min(remaining, W − (address mod W)) bytes, where W is the acknowledged width in bytes. An 8-bit port always moves one byte.
- R6: On a write, the data lane order is fixed: lane 0 is bits 31..24, lane 1 is bits 23..16, lane 2 is bits 15..8 and lane 3 is bits 7..0. An 8-bit port samples lane 0. A 16-bit port samples lanes 0–1 at base address A&~1. A 32-bit port samples lanes 0–3 at base address A&~3. Every sampled lane whose byte address falls in the moved range carries that operand byte; the operand is big-endian, with the most significant byte at the lowest address.
- R7: On a read, `rsp_done` pulses for exactly one clock, on the cycle after the final acknowledge. `rsp_rdata` then holds the operand right-justified and big-endian, built from the lanes defined in R6.
- R8: `bus_strobe` is high exactly while a sequence is in progress. `bus_write` equals the request's `req_write` throughout.
- R9: A long-word write to an odd address on a 16-bit port takes exactly three acknowledged cycles. The top byte goes on lane 1, then a word on lanes 0–1, then the lowest byte on lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code (01 byte, 10 word, 00 long) |
| req_addr | input | 32 | Byte address of the operand's most significant byte |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_done | output | 1 | One-clock pulse when the sequence ends |
| rsp_rdata | output | 32 | Assembled read operand, right-justified |
| bus_addr | output | 32 | Bus cycle address |
| bus_siz | output | 2 | Remaining-bytes code |
| bus_write | output | 1 | Bus direction |
| bus_strobe | output | 1 | Bus cycle active |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_rdata | input | 32 | Read data from the slave |
| bus_ack | input | 2 | Size acknowledge / wait |

## Verification
The bench targets misaligned operands that cross a port boundary. A wrong byte count per cycle would show up there as a skipped or repeated address, or as a size code that does not shrink correctly. It mixes wait states into cycles to catch a sequencer that advances without an acknowledge. It checks every lane that the acknowledged port samples on writes, and the byte order of merged reads, so a wrong lane for an odd offset on a 16-bit port or a 32-bit port is exposed. The three-cycle odd long-word write is run directly to pin down the exact cycle count.

// File: rtl/dbs_seq.sv
module dbs_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_done,
  output logic [31:0]   rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic          bus_write,
  output logic          bus_strobe,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic [1:0]    bus_ack
);
  logic          busy, wr, done;
  logic [AW-1:0] addr;
  logic [31:0]   wbuf, rbuf, got;
  logic [2:0]    rem, pw, cap, n, len;
  logic [1:0]    o, start;
  logic [7:0]    ln1, ln2, ln3;

  assign req_ready  = !busy;
  assign bus_strobe = busy;
  assign bus_addr   = addr;
  assign bus_siz    = rem[1:0];
  assign bus_write  = wr;
  assign rsp_done   = done;
  assign rsp_rdata  = rbuf;
  assign o          = addr[1:0];
  assign len        = (req_size == 2'b00) ? 3'd4 : {1'b0, req_size};

  always_comb begin
    case (bus_ack)
      2'b01:   begin pw = 3'd1; start = 2'd0; end
      2'b10:   begin pw = 3'd2; start = {1'b0, o[0]}; end
      2'b11:   begin pw = 3'd4; start = o; end
      default: begin pw = 3'd0; start = 2'd0; end
    endcase
  end

  assign cap = pw - {1'b0, start};
  assign n   = (rem < cap) ? rem : cap;

  assign ln1 = o[0] ? wbuf[31:24] : wbuf[23:16];
  always_comb begin
    case (o)
      2'd0:    begin ln2 = wbuf[15:8];  ln3 = wbuf[7:0];   end
      2'd1:    begin ln2 = wbuf[23:16]; ln3 = wbuf[15:8];  end
      2'd2:    begin ln2 = wbuf[31:24]; ln3 = wbuf[23:16]; end
      default: begin ln2 = wbuf[31:24]; ln3 = wbuf[31:24]; end
    endcase
  end
  assign bus_wdata = {wbuf[31:24], ln1, ln2, ln3};

  assign got = (bus_rdata << {start, 3'b000}) >> {3'd4 - n, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wr   <= 1'b0;
      done <= 1'b0;
      addr <= '0;
      rem  <= 3'd0;
      wbuf <= '0;
      rbuf <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && req_valid) begin
        busy <= 1'b1;
        wr   <= req_write;
        addr <= req_addr;
        rem  <= len;
        wbuf <= req_wdata << {3'd4 - len, 3'b000};
        rbuf <= '0;
      end else if (busy && pw != 3'd0) begin
        addr <= addr + AW'(n);
        rem  <= rem - n;
        wbuf <= wbuf << {n, 3'b000};
        rbuf <= (rbuf << {n, 3'b000}) | got;
        if (rem == n) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_NOT_READY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> !req_ready);  // R1
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack == 2'b00) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_siz)));  // R4
  AST_ADDR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack != 2'b00) |=> (!bus_strobe || bus_addr != $past(bus_addr)));  // R3
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);  // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> $past(bus_strobe && bus_ack != 2'b00));  // R7
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && $past(bus_strobe)) |-> $stable(bus_write));  // R8
endmodule

// File: tb/dbs_seq_tb.sv
module dbs_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00, bus_ack = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_rdata = '0;
  logic        req_ready, rsp_done, bus_write, bus_strobe;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [1:0]  bus_siz;
  int errors = 0, checks = 0, cyc = 0, last_acks = 0;

  always #5 clk = ~clk;

  dbs_seq u_dut (.clk, .rst_n, .req_valid, .req_ready, .req_write, .req_size,
    .req_addr, .req_wdata, .rsp_done, .rsp_rdata, .bus_addr, .bus_siz,
    .bus_write, .bus_strobe, .bus_wdata, .bus_rdata, .bus_ack);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ 8'h5A ^ a[15:8];
  endfunction

  function automatic logic [7:0] op_byte(input logic [31:0] d, input int len, input int i);
    return 8'(d >> (8 * (len - 1 - i)));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_op(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input int wcode, input bit waits);
    int len, rem, done_n, w, n, cap;
    logic [31:0] cur, base, expr;
    len = (sz == 2'b00) ? 4 : int'(sz);
    rem = len; done_n = 0; cur = a; expr = '0; last_acks = 0;
    w = (wcode == 1) ? 1 : (wcode == 2) ? 2 : 4;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = $urandom;
    chk(req_ready == 1'b0, "R1 ready low in flight", 32'(req_ready), 0);
    while (rem > 0) begin
      chk(bus_strobe == 1'b1 && bus_write == wr, "R8 strobe/dir", {bus_strobe, bus_write}, {1'b1, wr});
      chk(bus_addr == cur, "R3 address", bus_addr, cur);
      chk(bus_siz == 2'(rem), "R2 size code", 32'(bus_siz), 32'(2'(rem)));
      if (waits && ($urandom % 3 == 0)) begin
        bus_ack = 2'b00;
        bus_rdata = $urandom;
      end else begin
        base = cur & ~32'(w - 1);
        cap = w - int'(cur - base);
        n = (rem < cap) ? rem : cap;
        bus_ack = 2'(wcode);
        bus_rdata = $urandom;
        for (int k = 0; k < w; k++) begin
          logic [31:0] ba;
          int off;
          ba = base + 32'(k);
          off = int'(ba - cur);
          bus_rdata[31 - 8*k -: 8] = mem_byte(ba);
          if (wr && ba >= cur && off < n)
            chk(bus_wdata[31 - 8*k -: 8] == op_byte(d, len, done_n + off),
                "R6 write lane", 32'(bus_wdata[31 - 8*k -: 8]), 32'(op_byte(d, len, done_n + off)));
        end
        for (int i = 0; i < n; i++) expr = (expr << 8) | 32'(mem_byte(cur + 32'(i)));
        rem -= n; done_n += n; cur += 32'(n); last_acks++;
      end
      @(negedge clk);
      chk(rem > 0 || rsp_done == 1'b1, "R5 sequence length", 32'(rsp_done), 1);
    end
    bus_ack = 2'b00;
    chk(rsp_done == 1'b1 && req_ready == 1'b1, "R7 done pulse", {rsp_done, req_ready}, 2'b11);
    if (!wr) chk(rsp_rdata == expr, "R7 read data", rsp_rdata, expr);
    chk(bus_strobe == 1'b0, "R8 strobe low after end", 32'(bus_strobe), 0);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R7 done one clock", 32'(rsp_done), 0);
  endtask

  initial begin
    logic [1:0] szs[3];
    szs[0] = 2'b01; szs[1] = 2'b10; szs[2] = 2'b00;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && bus_strobe == 1'b0 && rsp_done == 1'b0, "R1 reset state",
        {req_ready, bus_strobe, rsp_done}, 3'b100);
    rst_n = 1'b1;
    // R9: long write, odd address, 16-bit port, no waits
    run_op(1'b1, 2'b00, 32'h0000_1001, 32'hA1B2C3D4, 2, 1'b0);
    chk(last_acks == 3, "R9 three cycles", last_acks, 3);
    // R5: 8-bit port moves one byte per cycle
    run_op(1'b0, 2'b00, 32'h0000_2002, 32'h0, 1, 1'b0);
    chk(last_acks == 4, "R5 byte port cycles", last_acks, 4);
    // R5: 32-bit port, offset 3 long word
    run_op(1'b0, 2'b00, 32'h0000_3003, 32'h0, 3, 1'b1);
    chk(last_acks == 2, "R5 wide port misaligned", last_acks, 2);
    run_op(1'b1, 2'b10, 32'h0000_4003, 32'h0000_BEEF, 3, 1'b1);
    chk(last_acks == 2, "R5 word across boundary", last_acks, 2);
    for (int t = 0; t < 400; t++)
      run_op(1'($urandom % 2), szs[$urandom % 3], $urandom, $urandom,
             int'($urandom % 3) + 1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule